// File: doc/BRIEF.md
# Redundant Reference Clock Switch Controller

This block supervises two redundant reference clocks against a common feedback clock and decides which reference should feed a downstream clock multiplexer. All three clocks are oversampled by a faster sampling clock through two-flop synchronizers. Edge detection then runs in the sampling domain. A reference that lets a programmable number of feedback rising edges pass without a rising edge of its own is marked as failed. Its failure flag stays set until an alarm reset clears it.

In automatic mode the controller leaves a failed active reference for the other one, provided the other is still healthy. With the override input high, the selection instead tracks the select input alone. A falling edge on the active-low alarm reset clears both failure flags, restarts both detection windows and reloads the selection from the select input. Holding that pin low has no further effect. Every selection change is registered and then frozen for a minimum number of sampling cycles, so the multiplexer select cannot chatter. The multiplexer select is provided as a one-hot pair next to a plain indicator bit.

Top module: `refsw_guard`

## Requirements
- R1: For each reference, a rising-edge counter counts feedback rising edges seen since that reference's last rising edge. When it reaches WINDOW (default 4), that reference's fail flag goes high. A reference rising edge clears the count, and a feedback rising edge in the same synchronized cycle is then not counted. A flag rises three sampling-clock edges after the input edge that completes the window.
- R2: A fail flag, once high, stays high until an alarm reset action.
- R3: A falling edge of alarmRstN (active low), taken through the synchronizer, clears both fail flags and both counts and loads clkSel from selIn. All of this happens three sampling edges after the pin falls. In that cycle the clear wins over a new detection.
- R4: The alarm reset is a one-shot. Holding alarmRstN low neither keeps flags cleared nor blocks a new detection, and its rising edge has no effect.
- R5: In automatic mode (overrideIn low), when the active reference's flag is high and the other reference's flag is low, the selection moves to the other reference one sampling edge after the flag rises.
- R6: In automatic mode with both flags high, the selection keeps its current value.
- R7: With overrideIn high, failover is disabled and clkSel follows selIn, where 0 selects reference 0 and 1 selects reference 1.
- R8: After any change, clkSel keeps its value for at least HOLD_CYCLES (default 2) sampling cycles before another automatic or override-driven change. An alarm reset action may override this minimum.
- R9: During power-on reset (rstN low) both flags are 0, clkSel equals selIn, and both counts are 0.
- R10: muxSel is one-hot. Bit 0 enables reference 0 and bit 1 enables reference 1, so muxSel is 2'b01 when clkSel is 0 and 2'b10 when clkSel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than all supervised clocks |
| rstN | input | 1 | Power-on reset, active low, synchronous |
| ref0In | input | 1 | Reference clock 0 (asynchronous) |
| ref1In | input | 1 | Reference clock 1 (asynchronous) |
| fbIn | input | 1 | Feedback clock (asynchronous) |
| selIn | input | 1 | Manual select: 0 reference 0, 1 reference 1 |
| overrideIn | input | 1 | High disables automatic failover |
| alarmRstN | input | 1 | Alarm reset, active low, acts on its falling edge |
| bad0 | output | 1 | Sticky failure flag of reference 0 |
| bad1 | output | 1 | Sticky failure flag of reference 1 |
| clkSel | output | 1 | Selected reference indicator |
| muxSel | output | 2 | One-hot enables for the downstream clock multiplexer |

## Verification
The hardest condition to reach from the ports is a failure detected while the alarm reset pin is still held low, followed by the pin's release. This is what separates a one-shot reset from a level reset. The stimulus holds alarmRstN low across a full window of feedback edges on a frozen reference, then raises it, and checks that the flag survives both. A second hard condition is the minimum hold: in override mode the bench toggles the select input every sampling cycle, which tries to force back-to-back changes. The random phase changes how often each reference toggles, so windows expire, reset and coincide with feedback edges in many orders.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

  // Strobes from the control unit to the detection datapath.
  typedef struct packed {
    logic clearFlags;     // drop both sticky failure flags
    logic restartWindow;  // zero both edge counters
  } ctlStrb_t;

  localparam int NUM_REFS = 2;

endpackage

// File: rtl/refsw_sync.sv
module refsw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) begin
      stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/refsw_datapath.sv
module refsw_datapath
  import refsw_pkg::*;
#(
  parameter int WINDOW      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REFS-1:0] refIn,
  input  logic                fbIn,
  input  ctlStrb_t            strb,
  output logic [NUM_REFS-1:0] badFlag
);

  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(WINDOW - 1);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(WINDOW);

  logic [NUM_REFS:0] rawIn, syncIn, prevIn, riseIn;
  logic [NUM_REFS-1:0] refRise;
  logic fbRise;

  assign rawIn = {fbIn, refIn};

  refsw_sync #(.W(NUM_REFS + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .d  (rawIn),
    .q  (syncIn)
  );

  // Previous sample; during reset it tracks the input so no edge is seen at release.
  always_ff @(posedge clk) begin
    prevIn <= syncIn;
  end

  assign riseIn  = syncIn & ~prevIn & {(NUM_REFS + 1){rstN}};
  assign refRise = riseIn[NUM_REFS-1:0];
  assign fbRise  = riseIn[NUM_REFS];

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
    logic [CNT_W-1:0] edgeCnt;

    always_ff @(posedge clk) begin
      if (!rstN || strb.restartWindow) begin
        edgeCnt <= '0;
      end else if (refRise[g]) begin
        edgeCnt <= '0;
      end else if (fbRise && edgeCnt != FULL) begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || strb.clearFlags) begin
        badFlag[g] <= 1'b0;
      end else if (fbRise && !refRise[g] && edgeCnt >= LAST_EDGE) begin
        badFlag[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int HOLD_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selIn,
  input  logic                overrideIn,
  input  logic                alarmRstN,
  input  logic [NUM_REFS-1:0] badFlag,
  output ctlStrb_t            strb,
  output logic                clkSel,
  output logic [NUM_REFS-1:0] muxSel
);

  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES - 1);

  logic alarmS, ovrS, selS;
  logic alarmPrev, alarmFall;
  logic activeBad, otherBad, wantSwitch, holdFree;
  logic nextSel, selChanged;
  logic [HOLD_W-1:0] holdCnt;

  refsw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .d  ({alarmRstN, overrideIn, selIn}),
    .q  ({alarmS, ovrS, selS})
  );

  // One-shot on the falling edge of the synchronized alarm reset.
  always_ff @(posedge clk) begin
    if (!rstN) alarmPrev <= 1'b0;
    else       alarmPrev <= alarmS;
  end

  assign alarmFall          = alarmPrev & ~alarmS;
  assign strb.clearFlags    = alarmFall;
  assign strb.restartWindow = alarmFall;

  assign activeBad  = badFlag[clkSel];
  assign otherBad   = badFlag[!clkSel];
  assign holdFree   = (holdCnt == '0);
  assign wantSwitch = ovrS ? (selS != clkSel) : (activeBad && !otherBad);

  always_comb begin
    nextSel = clkSel;
    if (alarmFall) begin
      nextSel = selS;
    end else if (holdFree && wantSwitch) begin
      nextSel = ~clkSel;
    end
  end

  assign selChanged = (nextSel != clkSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSel  <= selIn;
      muxSel  <= {selIn, ~selIn};
      holdCnt <= '0;
    end else begin
      clkSel <= nextSel;
      muxSel <= {nextSel, ~nextSel};
      if (selChanged)      holdCnt <= HOLD_LOAD;
      else if (!holdFree)  holdCnt <= holdCnt - 1'b1;
    end
  end

endmodule

// File: rtl/refsw_guard.sv
module refsw_guard
  import refsw_pkg::*;
#(
  parameter int WINDOW      = 4,
  parameter int HOLD_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ref0In,
  input  logic       ref1In,
  input  logic       fbIn,
  input  logic       selIn,
  input  logic       overrideIn,
  input  logic       alarmRstN,
  output logic       bad0,
  output logic       bad1,
  output logic       clkSel,
  output logic [1:0] muxSel
);

  ctlStrb_t ctlStrb;
  logic [NUM_REFS-1:0] badFlag;

  refsw_datapath #(.WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .refIn  ({ref1In, ref0In}),
    .fbIn   (fbIn),
    .strb   (ctlStrb),
    .badFlag(badFlag)
  );

  refsw_ctrl #(.HOLD_CYCLES(HOLD_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .selIn     (selIn),
    .overrideIn(overrideIn),
    .alarmRstN (alarmRstN),
    .badFlag   (badFlag),
    .strb      (ctlStrb),
    .clkSel    (clkSel),
    .muxSel    (muxSel)
  );

  assign bad0 = badFlag[0];
  assign bad1 = badFlag[1];

endmodule

// File: rtl/refsw_guard_chk.sv
module refsw_guard_chk #(
  parameter int HOLD_CYCLES = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       bad0,
  input logic       bad1,
  input logic       clkSel,
  input logic [1:0] muxSel,
  input logic       clearStb
);

  localparam int GAP_W = $clog2(HOLD_CYCLES + 1) + 1;

  logic             prevSel, clrD;
  logic [GAP_W-1:0] sinceChg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSel  <= clkSel;
      clrD     <= 1'b0;
      sinceChg <= GAP_W'(HOLD_CYCLES);
    end else begin
      prevSel <= clkSel;
      clrD    <= clearStb;
      if (clkSel != prevSel)                     sinceChg <= GAP_W'(1);
      else if (sinceChg < GAP_W'(HOLD_CYCLES))   sinceChg <= sinceChg + 1'b1;
    end
  end

  // R2
  sticky_bad0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bad0 && !clearStb) |=> bad0);

  // R2
  sticky_bad1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bad1 && !clearStb) |=> bad1);

  // R3
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> (!bad0 && !bad1));

  // R10
  mux_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(muxSel) && (muxSel[1] == clkSel));

  // R8
  min_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((clkSel != prevSel) && !clrD) |-> (sinceChg >= GAP_W'(HOLD_CYCLES)));

endmodule

bind refsw_guard refsw_guard_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .bad0    (bad0),
  .bad1    (bad1),
  .clkSel  (clkSel),
  .muxSel  (muxSel),
  .clearStb(ctlStrb.clearFlags)
);

// File: tb/sim_refsw_guard.sv
module sim_refsw_guard;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int STEP       = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ref0In = 1'b0, ref1In = 1'b0, fbIn = 1'b0;
  logic selIn = 1'b1, overrideIn = 1'b0, alarmRstN = 1'b1;
  logic bad0, bad1, clkSel;
  logic [1:0] muxSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  bit mBad [2];
  int mCnt [2];
  bit mCur;

  always #(CLK_PERIOD/2) clk = ~clk;

  refsw_guard u0 (
    .clk(clk), .rstN(rstN), .ref0In(ref0In), .ref1In(ref1In), .fbIn(fbIn),
    .selIn(selIn), .overrideIn(overrideIn), .alarmRstN(alarmRstN),
    .bad0(bad0), .bad1(bad1), .clkSel(clkSel), .muxSel(muxSel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [1:0] expMux(input bit s);
    return s ? 2'b10 : 2'b01;
  endfunction

  // Selection rule applied after each settled change (R5, R6, R7)
  function automatic void applySel();
    if (overrideIn) mCur = selIn;
    else if (mBad[mCur] && !mBad[!mCur]) mCur = !mCur;
  endfunction

  task automatic compareAll(input string tag);
    chk({tag, " bad0"}, bad0, mBad[0]);
    chk({tag, " bad1"}, bad1, mBad[1]);
    chk({tag, " clkSel"}, clkSel, mCur);
    chk({tag, " R10 muxSel"}, muxSel, expMux(mCur));
  endtask

  task automatic waitSteps();
    repeat (STEP) @(negedge clk);
  endtask

  // Drive new clock levels, update model per R1, then settle and compare.
  task automatic step(input bit n0, input bit n1, input bit nf, input string tag);
    bit r0, r1, rf;
    @(negedge clk);
    r0 = n0 && !ref0In; r1 = n1 && !ref1In; rf = nf && !fbIn;
    ref0In = n0; ref1In = n1; fbIn = nf;
    for (int i = 0; i < 2; i++) begin
      bit rr;
      rr = (i == 0) ? r0 : r1;
      if (rr) mCnt[i] = 0;
      else if (rf) begin
        if (mCnt[i] < W) mCnt[i]++;
        if (mCnt[i] >= W) mBad[i] = 1'b1;
      end
    end
    applySel();
    waitSteps();
    compareAll(tag);
  endtask

  // n feedback rising edges; references toggle on every step when asked
  task automatic fbRises(input int n, input bit t0, input bit t1, input string tag);
    for (int k = 0; k < 2 * n; k++) begin
      step(t0 ? !ref0In : ref0In, t1 ? !ref1In : ref1In, !fbIn, tag);
    end
  endtask

  task automatic setCtl(input bit s, input bit o, input string tag);
    @(negedge clk);
    selIn = s; overrideIn = o;
    applySel();
    waitSteps();
    compareAll(tag);
  endtask

  task automatic alarmLow(input string tag);
    @(negedge clk);
    alarmRstN = 1'b0;
    mBad[0] = 1'b0; mBad[1] = 1'b0; mCnt[0] = 0; mCnt[1] = 0;
    mCur = selIn;
    waitSteps();
    compareAll(tag);
  endtask

  task automatic alarmHigh(input string tag);
    @(negedge clk);
    alarmRstN = 1'b1;
    waitSteps();
    compareAll(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c3b_5a07));
    // R9: reset loads the selection from selIn
    repeat (5) @(negedge clk);
    chk("R9 bad0 in reset", bad0, 0);
    chk("R9 bad1 in reset", bad1, 0);
    chk("R9 clkSel in reset", clkSel, 1);
    chk("R10 muxSel in reset", muxSel, 2'b10);
    mBad[0] = 0; mBad[1] = 0; mCnt[0] = 0; mCnt[1] = 0; mCur = 1'b1;
    rstN = 1'b1;
    waitSteps();
    compareAll("R9 after release");

    // R1: three edges, restart, then exactly WINDOW edges
    fbRises(3, 1'b1, 1'b0, "R1 below window");
    chk("R1 no flag below window", bad1, 0);
    step(ref0In, 1'b1, fbIn, "R1 ref rise restarts");
    fbRises(3, 1'b1, 1'b0, "R1 after restart");
    chk("R1 still clear after restart", bad1, 0);
    fbRises(1, 1'b1, 1'b0, "R1 R5 window reached");
    chk("R1 flag at window", bad1, 1);
    chk("R5 failover to ref0", clkSel, 0);

    // R2: flag stays with no further activity
    step(ref0In, ref1In, fbIn, "R2 idle");
    step(!ref0In, !ref1In, fbIn, "R2 ref activity");
    chk("R2 sticky bad1", bad1, 1);

    // R6: both references fail, selection holds
    fbRises(W, 1'b0, 1'b0, "R6 both bad");
    chk("R6 both flags", bad0 & bad1, 1);
    chk("R6 hold selection", clkSel, 0);

    // R3: alarm reset clears and reloads from selIn
    setCtl(1'b1, 1'b0, "R6 sel change in auto");
    chk("R6 auto ignores selIn", clkSel, 0);
    alarmLow("R3 alarm");
    chk("R3 flags cleared", bad0 | bad1, 0);
    chk("R3 clkSel from selIn", clkSel, 1);

    // R4: detection while alarm still held low, release has no effect
    fbRises(W, 1'b1, 1'b0, "R4 detect while low");
    chk("R4 flag set while alarm low", bad1, 1);
    alarmHigh("R4 release");
    chk("R4 release keeps flag", bad1, 1);

    // R7: override follows selIn only
    setCtl(1'b1, 1'b1, "R7 override sel1");
    chk("R7 follows selIn despite bad1", clkSel, 1);
    setCtl(1'b0, 1'b1, "R7 override sel0");
    chk("R7 follows selIn 0", clkSel, 0);

    // R8: toggle selIn every cycle, no back-to-back changes
    begin
      bit lastSel, lastChg;
      int nChg;
      lastSel = clkSel; lastChg = 0; nChg = 0;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (clkSel != lastSel) begin
          nChg++;
          if (lastChg) chk("R8 change on consecutive cycles", 1, 0);
          lastChg = 1;
        end else lastChg = 0;
        lastSel = clkSel;
        selIn = !selIn;
      end
      chk("R8 selection still moved", nChg > 0, 1);
      setCtl(1'b1, 1'b1, "R8 settle");
    end
    setCtl(1'b1, 1'b0, "R5 back to auto");

    // Random phase
    for (int blk = 0; blk < 8; blk++) begin
      int p0, p1;
      p0 = (blk % 3 == 0) ? 0 : ((blk % 3 == 1) ? 15 : 60);
      p1 = (blk % 4 == 2) ? 5 : 55;
      for (int k = 0; k < 40; k++) begin
        int r;
        r = $urandom_range(0, 99);
        if (r < 5) begin
          alarmLow("R3 random alarm");
          alarmHigh("R4 random release");
        end else if (r < 9) begin
          setCtl($urandom_range(0, 1), ($urandom_range(0, 3) == 0), "R7 random ctl");
        end else begin
          step(($urandom_range(0, 99) < p0) ? !ref0In : ref0In,
               ($urandom_range(0, 99) < p1) ? !ref1In : ref1In,
               ($urandom_range(0, 1) == 1) ? !fbIn : fbIn, "R1 R5 random");
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule